// File: doc/BRIEF.md
# Shadowed device register synchronizer

This block holds a local copy of a remote peripheral's register file and keeps the copy and the device consistent. Software updates the copy through the write side of an AXI4-Lite slave. The port carries a register index, 32 bits of data and per-byte strobes. A per-lane writable mask decides which bytes the host may change. Every host write marks its register as pending.

A small controller owns the device side. When no register is pending and the block has been idle for a set number of cycles, it pulses a read request. It then takes the device's register contents back one byte per AXI4-Stream beat. The beat order is byte 0 of register 0 first and the top byte of the last register last. A returned byte is dropped when its register is pending, so a fresh host value is never overwritten by stale device data.

Pending registers are pushed to the device on an output byte stream, lowest index first. Each register goes out as one header beat followed by four data beats. The pending flag clears only when the final beat is accepted and no newer host write has reached that register during the request.

Top module: `shadow_regfile_sync`

## Requirements
- R1: While `rst_n` is low, and after it is released, all registers read as zero, no register is pending, and `rd_req`, `m_tvalid` and `s_tready` are low.
- R2: A host write updates byte lane b (bits 8b+7..8b) of the indexed register only when `host_wr_strb[b]` is 1 and the writable mask allows that lane. With the default mask, lane 3 of register 15 ignores host writes.
- R3: A host write marks its register pending, even when all strobes are 0. Pending registers are sent lowest index first. Each request is five beats: a header byte equal to index*4, then data lanes 0 to 3, with `m_tlast` on the last one. The data is captured in the cycle the request starts.
- R4: A register's pending flag clears when its `m_tlast` beat is accepted, and the register is not sent again. If the host wrote that register between capture and that acceptance (inclusive), the flag stays set and the register is sent again with the new value.
- R5: After POLL_GAP consecutive idle clock edges with nothing pending, `rd_req` is high for exactly one cycle. `s_tready` goes high in the next cycle. Pending sends always go before a poll.
- R6: Read-back beats are counted from 0 at each request. Accepted beat k is stored in register k/4, lane k%4, whatever the host mask says. After the 64th accepted beat `s_tready` drops and the block returns to idle.
- R7: A read-back byte whose register is pending is consumed but not stored.
- R8: In a cycle with `host_wr_en` high, `s_tready` is low. The host write wins, and the held beat is stored on a later cycle.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` stays stable.
- R10: A one-cycle `soft_rst` clears registers, pending flags and the controller as R1 does, at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous clear of the whole block |
| host_wr_en | input | 1 | Host write strobe (accepted AXI4-Lite write) |
| host_wr_idx | input | 4 | Register index (address bits above the byte offset) |
| host_wr_data | input | 32 | Host write data |
| host_wr_strb | input | 4 | Host byte strobes |
| rd_req | output | 1 | One-cycle request for a full device read-back |
| s_tvalid | input | 1 | Read-back stream valid |
| s_tready | output | 1 | Read-back stream ready |
| s_tdata | input | 8 | Read-back byte |
| m_tvalid | output | 1 | Device-write stream valid |
| m_tready | input | 1 | Device-write stream ready |
| m_tdata | output | 8 | Header or data byte |
| m_tlast | output | 1 | Last beat of a register write request |

## Verification
The hardest case to reach is a host write that lands while a read-back is in flight. That register must stay pending while its own bytes stream past, and the returned data must neither overwrite it nor be lost for neighbouring registers. The bench waits for the timed read request and feeds 64 known bytes. Partway through, it raises a host write to a register whose bytes have not arrived yet, while a beat is being offered. It then forces strobe-free host writes so the stored read-back values come out on the device-write stream and can be compared. A rewrite during a stalled request is set up by holding `m_tready` low.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDREQ = 2'd1,
    ST_AWAIT = 2'd2,
    ST_SEND  = 2'd3
  } srf_state_e;
endpackage

// File: rtl/srf_regbank.sv
module srf_regbank #(
  parameter int NREG = 16,
  parameter int DW = 32,
  parameter logic [NREG*(DW/8)-1:0] WMASK = '1
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      soft_rst,
  input  logic                      wr_en,
  input  logic [$clog2(NREG)-1:0]   wr_idx,
  input  logic [DW/8-1:0]           wr_strb,
  input  logic [DW-1:0]             wr_data,
  input  logic                      rb_store,
  input  logic [$clog2(NREG)-1:0]   rb_idx,
  input  logic [$clog2(DW/8)-1:0]   rb_lane,
  input  logic [7:0]                rb_byte,
  input  logic                      pend_clr,
  input  logic [$clog2(NREG)-1:0]   pend_clr_idx,
  output logic [NREG-1:0][DW-1:0]   regs_o,
  output logic [NREG-1:0]           pend_o
);
  localparam int LANES = DW / 8;
  localparam int IW    = $clog2(NREG);
  localparam int LW    = $clog2(LANES);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic [DW-1:0] r_q;
    logic [DW-1:0] r_d;
    logic          p_q;
    logic          p_d;
    logic          wr_hit;
    logic          rb_hit;

    assign wr_hit = wr_en && (wr_idx == IW'(gi));
    assign rb_hit = rb_store && (rb_idx == IW'(gi)) && !p_q;

    always_comb begin
      r_d = r_q;
      for (int b = 0; b < LANES; b++) begin
        if (wr_hit && wr_strb[b] && WMASK[gi*LANES+b]) begin
          r_d[b*8 +: 8] = wr_data[b*8 +: 8];
        end else if (rb_hit && (rb_lane == LW'(b))) begin
          r_d[b*8 +: 8] = rb_byte;
        end
      end
      if (soft_rst) r_d = '0;
    end

    always_comb begin
      p_d = p_q;
      if (wr_hit) p_d = 1'b1;
      else if (pend_clr && (pend_clr_idx == IW'(gi))) p_d = 1'b0;
      if (soft_rst) p_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
        p_q <= 1'b0;
      end else begin
        r_q <= r_d;
        p_q <= p_d;
      end
    end

    assign regs_o[gi] = r_q;
    assign pend_o[gi] = p_q;

    for (genvar gb = 0; gb < LANES; gb++) begin : g_lock
      if (!WMASK[gi*LANES+gb]) begin : g_ro
        assert_locked_lane_R2: assert property (@(posedge clk) disable iff (!rst_ni)
          (wr_hit && !rb_store && !soft_rst) |=> $stable(r_q[gb*8 +: 8]));
      end
    end
  end

  assert_pending_set_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !soft_rst) |=> pend_o[$past(wr_idx)]);

  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rb_store && pend_o[rb_idx] && !soft_rst) |=> (regs_o[$past(rb_idx)] == $past(regs_o[rb_idx])));
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW = 32,
  parameter int POLL_GAP = 64
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      soft_rst,
  input  logic                      host_wr_en,
  input  logic [$clog2(NREG)-1:0]   host_wr_idx,
  input  logic [NREG-1:0][DW-1:0]   regs_i,
  input  logic [NREG-1:0]           pend_i,
  output logic                      rd_req,
  input  logic                      s_tvalid,
  output logic                      s_tready,
  output logic                      rb_store,
  output logic [$clog2(NREG)-1:0]   rb_idx,
  output logic [$clog2(DW/8)-1:0]   rb_lane,
  output logic                      m_tvalid,
  input  logic                      m_tready,
  output logic [7:0]                m_tdata,
  output logic                      m_tlast,
  output logic                      pend_clr,
  output logic [$clog2(NREG)-1:0]   pend_clr_idx
);
  localparam int LANES = DW / 8;
  localparam int IW    = $clog2(NREG);
  localparam int LW    = $clog2(LANES);
  localparam int AW    = IW + LW;
  localparam int BW    = $clog2(LANES + 1);
  localparam int PW    = $clog2(POLL_GAP + 1);
  localparam logic [AW-1:0] LAST_BEAT = AW'(NREG * LANES - 1);

  srf_state_e      state_q, state_d;
  logic [PW-1:0]   poll_q, poll_d;
  logic [AW-1:0]   rbc_q, rbc_d;
  logic [BW-1:0]   beat_q, beat_d;
  logic [IW-1:0]   sidx_q, sidx_d;
  logic [DW-1:0]   snap_q, snap_d;
  logic            hit_q, hit_d;
  logic [IW-1:0]   sel;
  logic            any_pend;
  logic            s_acc, m_acc;
  logic [7:0]      hdr;

  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pend_i[i]) sel = IW'(i);
    end
  end
  assign any_pend = |pend_i;

  assign rd_req   = (state_q == ST_RDREQ);
  assign s_tready = (state_q == ST_AWAIT) && !host_wr_en;
  assign s_acc    = s_tvalid && s_tready;
  assign rb_store = s_acc;
  assign rb_idx   = rbc_q[AW-1:LW];
  assign rb_lane  = rbc_q[LW-1:0];

  always_comb begin
    hdr = '0;
    hdr[AW-1:LW] = sidx_q;
  end
  assign m_tvalid     = (state_q == ST_SEND);
  assign m_tlast      = m_tvalid && (beat_q == BW'(LANES));
  assign m_tdata      = (beat_q == '0) ? hdr : snap_q[7:0];
  assign m_acc        = m_tvalid && m_tready;
  assign pend_clr     = m_acc && m_tlast && !hit_q;
  assign pend_clr_idx = sidx_q;

  always_comb begin
    state_d = state_q;
    poll_d  = poll_q;
    rbc_d   = rbc_q;
    beat_d  = beat_q;
    sidx_d  = sidx_q;
    snap_d  = snap_q;
    hit_d   = hit_q;
    if ((state_q == ST_IDLE) && !any_pend && (poll_q != PW'(POLL_GAP - 1))) poll_d = poll_q + 1'b1;
    else poll_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_pend) begin
          state_d = ST_SEND;
          sidx_d  = sel;
          snap_d  = regs_i[sel];
          beat_d  = '0;
          hit_d   = host_wr_en && (host_wr_idx == sel);
        end else if (poll_q == PW'(POLL_GAP - 1)) begin
          state_d = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        state_d = ST_AWAIT;
        rbc_d   = '0;
      end
      ST_AWAIT: begin
        if (s_acc) begin
          rbc_d = rbc_q + 1'b1;
          if (rbc_q == LAST_BEAT) state_d = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (host_wr_en && (host_wr_idx == sidx_q)) hit_d = 1'b1;
        if (m_acc) begin
          beat_d = beat_q + 1'b1;
          if (beat_q != '0) snap_d = snap_q >> 8;
          if (m_tlast) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (soft_rst) begin
      state_d = ST_IDLE;
      poll_d  = '0;
      rbc_d   = '0;
      beat_d  = '0;
      hit_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      rbc_q   <= '0;
      beat_q  <= '0;
      sidx_q  <= '0;
      snap_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      rbc_q   <= rbc_d;
      beat_q  <= beat_d;
      sidx_q  <= sidx_d;
      snap_q  <= snap_d;
      hit_q   <= hit_d;
    end
  end

  assert_poll_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && !soft_rst) |=> !rd_req);

  assert_host_blocks_rb_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    host_wr_en |-> !s_tready);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (m_tvalid && !m_tready && !soft_rst) |=> (m_tvalid && $stable(m_tdata)));

  assert_rb_done_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (s_acc && (rbc_q == LAST_BEAT) && !soft_rst) |=> (!s_tready && !rd_req));
endmodule

// File: rtl/shadow_regfile_sync.sv
module shadow_regfile_sync #(
  parameter int NREG = 16,
  parameter int DW = 32,
  parameter int POLL_GAP = 64,
  parameter logic [NREG*(DW/8)-1:0] WMASK = {1'b0, {(NREG*(DW/8)-1){1'b1}}}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    host_wr_en,
  input  logic [$clog2(NREG)-1:0] host_wr_idx,
  input  logic [DW-1:0]           host_wr_data,
  input  logic [DW/8-1:0]         host_wr_strb,
  output logic                    rd_req,
  input  logic                    s_tvalid,
  output logic                    s_tready,
  input  logic [7:0]              s_tdata,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [7:0]              m_tdata,
  output logic                    m_tlast
);
  localparam int LANES = DW / 8;
  localparam int IW    = $clog2(NREG);
  localparam int LW    = $clog2(LANES);

  logic [1:0]               rst_sync_q;
  logic                     rst_ni;
  logic [NREG-1:0][DW-1:0]  regs;
  logic [NREG-1:0]          pend;
  logic                     rb_store;
  logic [IW-1:0]            rb_idx;
  logic [LW-1:0]            rb_lane;
  logic                     pend_clr;
  logic [IW-1:0]            pend_clr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  srf_regbank #(.NREG(NREG), .DW(DW), .WMASK(WMASK)) u_bank (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .soft_rst     (soft_rst),
    .wr_en        (host_wr_en),
    .wr_idx       (host_wr_idx),
    .wr_strb      (host_wr_strb),
    .wr_data      (host_wr_data),
    .rb_store     (rb_store),
    .rb_idx       (rb_idx),
    .rb_lane      (rb_lane),
    .rb_byte      (s_tdata),
    .pend_clr     (pend_clr),
    .pend_clr_idx (pend_clr_idx),
    .regs_o       (regs),
    .pend_o       (pend)
  );

  srf_ctrl #(.NREG(NREG), .DW(DW), .POLL_GAP(POLL_GAP)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .soft_rst     (soft_rst),
    .host_wr_en   (host_wr_en),
    .host_wr_idx  (host_wr_idx),
    .regs_i       (regs),
    .pend_i       (pend),
    .rd_req       (rd_req),
    .s_tvalid     (s_tvalid),
    .s_tready     (s_tready),
    .rb_store     (rb_store),
    .rb_idx       (rb_idx),
    .rb_lane      (rb_lane),
    .m_tvalid     (m_tvalid),
    .m_tready     (m_tready),
    .m_tdata      (m_tdata),
    .m_tlast      (m_tlast),
    .pend_clr     (pend_clr),
    .pend_clr_idx (pend_clr_idx)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_ni) |-> (!rd_req && !m_tvalid && !s_tready));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst |=> (pend == '0 && !m_tvalid && !rd_req));
endmodule

// File: tb/sim_shadow_regfile_sync.sv
module sim_shadow_regfile_sync;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int GAP  = 64;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, host_wr_en;
  logic [3:0]  host_wr_idx;
  logic [31:0] host_wr_data;
  logic [3:0]  host_wr_strb;
  logic        rd_req, s_tvalid, s_tready;
  logic [7:0]  s_tdata;
  logic        m_tvalid, m_tready, m_tlast;
  logic [7:0]  m_tdata;

  always #4 clk = ~clk;

  shadow_regfile_sync #(.NREG(NREG), .DW(DW), .POLL_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
    .host_wr_data(host_wr_data), .host_wr_strb(host_wr_strb),
    .rd_req(rd_req), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    cyc_last = 0;
  bit    done = 1'b0;
  logic [8:0] expq[$];
  string      tagq[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every accepted output beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      logic [8:0] got;
      logic [8:0] exp;
      string      tg;
      got = {m_tlast, m_tdata};
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected beat actual %h expected none", got);
      end else begin
        exp = expq.pop_front();
        tg  = tagq.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s beat actual %h expected %h", tg, got, exp);
        end
      end
      if (m_tlast) cyc_last = cyc;
    end
  end

  function automatic logic [7:0] rbv(int k);
    return 8'(k * 7 + 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_req(input int idx, input logic [31:0] v, input string tag);
    expq.push_back({1'b0, 8'(idx * 4)});
    tagq.push_back(tag);
    for (int b = 0; b < 4; b++) begin
      expq.push_back({(b == 3), v[b*8 +: 8]});
      tagq.push_back(tag);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic hw(input int idx, input logic [3:0] strb, input logic [31:0] data);
    host_wr_en   = 1'b1;
    host_wr_idx  = 4'(idx);
    host_wr_strb = strb;
    host_wr_data = data;
    @(posedge clk);
    #1;
    host_wr_en = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; host_wr_en = 1'b0; host_wr_idx = '0;
    host_wr_data = '0; host_wr_strb = '0; s_tvalid = 1'b0; s_tdata = '0;
    m_tready = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R1 in reset outputs", {29'd0, rd_req, m_tvalid, s_tready}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R1 after release outputs", {29'd0, rd_req, m_tvalid, s_tready}, 32'd0);
    @(posedge clk); #1;

    // R2/R3: partial strobes, other lanes still zero from reset (R1)
    expect_req(3, 32'h00BB_00DD, "R2 strobed lanes");
    hw(3, 4'b0101, 32'hAABB_CCDD);
    drain();
    // R2: lane 3 of register 15 is host read-only
    expect_req(15, 32'h0022_3344, "R2 masked lane");
    hw(15, 4'b1111, 32'h1122_3344);
    drain();

    // R3 ordering and R9 stall
    m_tready = 1'b0;
    expect_req(5, 32'h0505_0505, "R3 first in flight");
    expect_req(2, 32'h0202_0202, "R3 lowest index next");
    expect_req(9, 32'h0909_0909, "R3 higher index last");
    hw(5, 4'hF, 32'h0505_0505);
    hw(9, 4'hF, 32'h0909_0909);
    hw(2, 4'hF, 32'h0202_0202);
    @(negedge clk);
    chk("R9 held header", {23'd0, m_tvalid, m_tdata}, {23'd0, 1'b1, 8'h14});
    tick(3);
    @(negedge clk);
    chk("R9 still held", {23'd0, m_tvalid, m_tdata}, {23'd0, 1'b1, 8'h14});
    @(posedge clk); #1;
    m_tready = 1'b1;
    drain();

    // R4: rewrite during a stalled request is sent again
    m_tready = 1'b0;
    expect_req(6, 32'h0102_0304, "R4 captured value");
    expect_req(6, 32'h0A0B_0C0D, "R4 resend new value");
    hw(6, 4'hF, 32'h0102_0304);
    tick(2);
    hw(6, 4'hF, 32'h0A0B_0C0D);
    m_tready = 1'b1;
    drain();
    tick(10);
    @(negedge clk);
    chk("R4 no further send", {31'd0, m_tvalid}, 32'd0);

    // R5: poll timing
    while (!rd_req) @(negedge clk);
    chk("R5 poll gap", 32'(cyc - cyc_last), 32'(GAP + 1));
    @(negedge clk);
    chk("R5 pulse width and await", {30'd0, rd_req, s_tready}, 32'd1);
    @(posedge clk); #1;

    // R6/R7/R8: read-back with a host write to register 12 in flight
    for (int k = 0; k < 64; k++) begin
      s_tvalid = 1'b1;
      s_tdata  = rbv(k);
      if (k == 20) begin
        host_wr_en = 1'b1; host_wr_idx = 4'd12; host_wr_strb = 4'b0001;
        host_wr_data = 32'h0000_00A5;
        @(negedge clk);
        chk("R8 ready low on host write", {31'd0, s_tready}, 32'd0);
        @(posedge clk); #1;
        host_wr_en = 1'b0;
      end
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_tvalid = 1'b0;
    expect_req(12, 32'h0000_00A5, "R7 pending kept");
    expect_req(5, {rbv(23), rbv(22), rbv(21), rbv(20)}, "R8 held beat stored");
    expect_req(7, {rbv(31), rbv(30), rbv(29), rbv(28)}, "R6 readback lanes");
    expect_req(15, {rbv(63), 24'h0}, "R6 last byte in locked lane");
    @(negedge clk);
    chk("R6 ready drops after last beat", {31'd0, s_tready}, 32'd0);
    @(posedge clk); #1;
    hw(5, 4'b0000, 32'hFFFF_FFFF);
    hw(7, 4'b0000, 32'hFFFF_FFFF);
    hw(15, 4'b1111, 32'h0000_0000);
    drain();

    // R10: soft reset clears contents
    soft_rst = 1'b1;
    tick(1);
    soft_rst = 1'b0;
    @(negedge clk);
    chk("R10 outputs after soft reset", {29'd0, rd_req, m_tvalid, s_tready}, 32'd0);
    @(posedge clk); #1;
    expect_req(5, 32'h0, "R10 register cleared");
    hw(5, 4'b0000, 32'hFFFF_FFFF);
    drain();
    tick(2);
    finish_run();
  end
endmodule